// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

This block raises a base to an exponent modulo an odd modulus of `W` bits, with `W` a parameter (16 by default). It works entirely in the Montgomery domain: the caller supplies the modulus together with two precomputed constants, 2^W mod n and 2^(2W) mod n. The engine first moves the base into the Montgomery domain by multiplying it with the second constant. It then runs a square-and-multiply loop from the most significant exponent bit down to bit zero, starting from the first constant, which is the value one in Montgomery form. Finally it leaves the domain by multiplying the accumulator with the plain value one.

Every modular product goes through a single radix-2 Montgomery multiplier that handles one multiplier bit per clock. One iteration is two chained conditional adders followed by a halving. There is no reduction by n inside the iteration loop. A single conditional subtraction at the end of each product keeps every operand below n.

The caller asserts `start` for one cycle with the operands on the inputs. The engine captures them, raises `busy`, and when the result is ready it pulses `done` for one cycle with `z` valid. `z` then holds its value until the next result.

Top module: `mexp_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` and `done` are 0 and `z` is 0.
- R2: For an odd modulus n, a base y < n, any W-bit exponent x, and correctly supplied constants `one_m_in` = 2^W mod n and `sq_m_in` = 2^(2W) mod n, the result is `z` = y^x mod n.
- R3: Every result presented with `done` is strictly below the captured modulus.
- R4: An exponent of zero gives `z` = 1 mod n. An exponent that is all ones makes the engine do a multiply at every bit position, and a base of zero gives `z` = 0 for any nonzero exponent.
- R5: All five operands are captured in the cycle `start` is accepted. Changing the operand inputs afterwards has no effect on the result in progress.
- R6: A `start` pulse while `busy` is 1 is ignored: the running result, its value and its latency are unchanged, and no second result follows.
- R7: `done` is high for exactly one cycle, `busy` is 0 in that cycle, and `z` changes only in a cycle where `done` is 1.
- R8: The number of clock edges from the edge that accepts `start` to the edge that raises `done` is 1 + (W+3)·(W+2+popcount(x)).
- R9: A `start` asserted in the very cycle `done` is high is accepted and begins a new computation, and that computation's result is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new exponentiation (accepted when not busy) |
| base_in | input | W | Base y, must be below n |
| exp_in | input | W | Exponent x |
| mod_in | input | W | Odd modulus n |
| one_m_in | input | W | Constant 2^W mod n |
| sq_m_in | input | W | Constant 2^(2W) mod n |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: `z` is valid |
| z | output | W | Result y^x mod n, held until the next `done` |

## Verification
Two events can fall in the same cycle: a result completing, when `done` pulses and `busy` drops, and a new `start` being accepted. The bench provokes this by raising `start` with fresh operands in the exact cycle it sees `done`. It then checks that the first result was delivered intact, that the engine went busy again on the next edge, and that the second result matches the arithmetic model. A second overlap, a `start` arriving mid-run with different operands, is judged by the result value and by the latency, which must still follow the formula for the original exponent.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

  // Sequencer phases of one exponentiation
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_CONV,
    SQ_SQR,
    SQ_MUL,
    SQ_OUT
  } seq_state_t;

  // Phases of one Montgomery product
  typedef enum logic [1:0] {
    MM_IDLE,
    MM_RUN,
    MM_END
  } mm_state_t;

endpackage

// File: rtl/mexp_step.sv
// One radix-2 Montgomery iteration: conditional add of b, conditional add of n, halve.
module mexp_step #(
  parameter int W = 16
) (
  input  logic [W:0]   p,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  input  logic         abit,
  output logic [W:0]   p_next
);
  localparam int SW = W + 2;

  logic [SW-1:0] sum_b;
  logic [SW-1:0] sum_n;

  always_comb begin
    sum_b  = {1'b0, p} + (abit ? {2'b00, b} : {SW{1'b0}});
    sum_n  = sum_b + (sum_b[0] ? {2'b00, n} : {SW{1'b0}});
    p_next = sum_n[SW-1:1];
  end
endmodule

// File: rtl/mexp_mont.sv
// Iterative Montgomery product a*b*2^-W mod n, one multiplier bit per cycle.
module mexp_mont
  import mexp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  output logic         done,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(W + 1);

  mm_state_t   st;
  logic [W-1:0] a_q, b_q, n_q;
  logic [W:0]   p_q, p_nx;
  logic [CW-1:0] cnt;
  logic [W:0]   p_sub;
  logic [W-1:0] p_red;

  mexp_step #(.W(W)) u_step (
    .p      (p_q),
    .b      (b_q),
    .n      (n_q),
    .abit   (a_q[0]),
    .p_next (p_nx)
  );

  always_comb begin
    p_sub = p_q - {1'b0, n_q};
    p_red = (p_q >= {1'b0, n_q}) ? p_sub[W-1:0] : p_q[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= MM_IDLE;
      a_q  <= '0;
      b_q  <= '0;
      n_q  <= '0;
      p_q  <= '0;
      cnt  <= '0;
      done <= 1'b0;
      res  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        MM_IDLE: begin
          if (go) begin
            a_q <= a;
            b_q <= b;
            n_q <= n;
            p_q <= '0;
            cnt <= '0;
            st  <= MM_RUN;
          end
        end
        MM_RUN: begin
          p_q <= p_nx;
          a_q <= a_q >> 1;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= MM_END;
        end
        MM_END: begin
          res  <= p_red;
          done <= 1'b1;
          st   <= MM_IDLE;
        end
        default: st <= MM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mexp_seq.sv
// Square-and-multiply sequencer in the Montgomery domain.
module mexp_seq
  import mexp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] y_q,
  input  logic [W-1:0] x_q,
  input  logic [W-1:0] r1_q,
  input  logic [W-1:0] r2_q,
  input  logic         mm_done,
  input  logic [W-1:0] mm_res,
  output logic         accept,
  output logic         mm_go,
  output logic [W-1:0] mm_a,
  output logic [W-1:0] mm_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] z
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] ONE = W'(1);

  seq_state_t   st;
  logic [IW-1:0] idx;
  logic [W-1:0] ty;

  assign accept = start && (st == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_IDLE;
      idx   <= '0;
      ty    <= '0;
      mm_go <= 1'b0;
      mm_a  <= '0;
      mm_b  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      z     <= '0;
    end else begin
      mm_go <= 1'b0;
      done  <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            busy <= 1'b1;
            st   <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          mm_go <= 1'b1;
          mm_a  <= y_q;
          mm_b  <= r2_q;
          st    <= SQ_CONV;
        end
        SQ_CONV: begin
          if (mm_done) begin
            ty    <= mm_res;
            mm_go <= 1'b1;
            mm_a  <= r1_q;
            mm_b  <= r1_q;
            idx   <= IW'(W - 1);
            st    <= SQ_SQR;
          end
        end
        SQ_SQR: begin
          if (mm_done) begin
            mm_go <= 1'b1;
            mm_a  <= mm_res;
            if (x_q[idx]) begin
              mm_b <= ty;
              st   <= SQ_MUL;
            end else if (idx == '0) begin
              mm_b <= ONE;
              st   <= SQ_OUT;
            end else begin
              mm_b <= mm_res;
              idx  <= idx - 1'b1;
            end
          end
        end
        SQ_MUL: begin
          if (mm_done) begin
            mm_go <= 1'b1;
            mm_a  <= mm_res;
            if (idx == '0) begin
              mm_b <= ONE;
              st   <= SQ_OUT;
            end else begin
              mm_b <= mm_res;
              idx  <= idx - 1'b1;
              st   <= SQ_SQR;
            end
          end
        end
        SQ_OUT: begin
          if (mm_done) begin
            z    <= mm_res;
            done <= 1'b1;
            busy <= 1'b0;
            st   <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mexp_engine.sv
// Top: operand capture, sequencer and Montgomery multiplier.
module mexp_engine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] base_in,
  input  logic [W-1:0] exp_in,
  input  logic [W-1:0] mod_in,
  input  logic [W-1:0] one_m_in,
  input  logic [W-1:0] sq_m_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] z
);
  logic [W-1:0] base_q, exp_q, mod_q, one_q, sq_q;
  logic         accept;
  logic         mm_go, mm_done;
  logic [W-1:0] mm_a, mm_b, mm_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      exp_q  <= '0;
      mod_q  <= '0;
      one_q  <= '0;
      sq_q   <= '0;
    end else if (accept) begin
      base_q <= base_in;
      exp_q  <= exp_in;
      mod_q  <= mod_in;
      one_q  <= one_m_in;
      sq_q   <= sq_m_in;
    end
  end

  mexp_seq #(.W(W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .y_q     (base_q),
    .x_q     (exp_q),
    .r1_q    (one_q),
    .r2_q    (sq_q),
    .mm_done (mm_done),
    .mm_res  (mm_res),
    .accept  (accept),
    .mm_go   (mm_go),
    .mm_a    (mm_a),
    .mm_b    (mm_b),
    .busy    (busy),
    .done    (done),
    .z       (z)
  );

  mexp_mont #(.W(W)) u_mont (
    .clk  (clk),
    .rst  (rst),
    .go   (mm_go),
    .a    (mm_a),
    .b    (mm_b),
    .n    (mod_q),
    .done (mm_done),
    .res  (mm_res)
  );
endmodule

// File: rtl/mexp_engine_chk.sv
module mexp_engine_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] z,
  input logic [W-1:0] mod_q,
  input logic         mm_done
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs idle in the cycle following a reset edge
  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_idle_R1: assert (!busy && !done && (z == '0))
        else $error("outputs not idle after reset");
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_z_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(z));

  assert_z_below_n_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (z < mod_q));

  assert_operands_held_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mod_q));

  assert_no_stray_product_R6: assert property (@(posedge clk) disable iff (rst)
    mm_done |-> busy);
endmodule

bind mexp_engine mexp_engine_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .z       (z),
  .mod_q   (mod_q),
  .mm_done (mm_done)
);

// File: tb/mexp_engine_bench.sv
module mexp_engine_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] base_in = '0, exp_in = '0, mod_in = '0, one_m_in = '0, sq_m_in = '0;
  logic         busy, done;
  logic [W-1:0] z;

  int errors = 0;
  int checks = 0;
  int wd = 0;

  always #10 clk = ~clk;

  mexp_engine #(.W(W)) u_mexp_engine (
    .clk(clk), .rst(rst), .start(start),
    .base_in(base_in), .exp_in(exp_in), .mod_in(mod_in),
    .one_m_in(one_m_in), .sq_m_in(sq_m_in),
    .busy(busy), .done(done), .z(z)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint model(input longint y, input longint x, input longint n);
    longint r;
    r = 1 % n;
    for (int i = W - 1; i >= 0; i--) begin
      r = (r * r) % n;
      if (x[i]) r = (r * y) % n;
    end
    return r;
  endfunction

  function automatic longint lat(input logic [W-1:0] x);
    return 1 + (W + 3) * (W + 2 + $countones(x));
  endfunction

  task automatic drive(input logic [W-1:0] y, input logic [W-1:0] x, input logic [W-1:0] n);
    longint nn;
    nn = n;
    base_in  = y;
    exp_in   = x;
    mod_in   = n;
    one_m_in = W'((longint'(1) << W) % nn);
    sq_m_in  = W'((longint'(1) << (2 * W)) % nn);
  endtask

  // Runs one computation; disturb pulses start with other operands mid-run (R5, R6)
  task automatic run_one(input logic [W-1:0] y, input logic [W-1:0] x,
                         input logic [W-1:0] n, input bit disturb, input string req);
    int cyc;
    longint expz;
    expz = model(y, x, n);
    @(negedge clk);
    drive(y, x, n);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 10) begin
        drive(y ^ 16'h5A5A, ~x, n ^ 16'h0F0E);
        start = 1'b1;
      end
      if (disturb && cyc == 11) start = 1'b0;
      if (done) break;
    end
    chk(z == W'(expz), req, "result", z, expz);
    chk(z < n, "R3", "result below modulus", z, n);
    chk(cyc == lat(x), "R8", "latency", cyc, lat(x));
    chk(!busy, "R7", "busy low in done cycle", busy, 0);
    @(negedge clk);
    chk(!done, "R7", "done one cycle only", done, 0);
    if (disturb) begin
      repeat (W + 5) @(negedge clk);
      chk(!done && !busy, "R6", "no second result after ignored start", done, 0);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 190000) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", wd, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] n, y, x, zfirst;
    longint e1, e2;
    repeat (3) @(negedge clk);
    chk(!busy && !done && z == '0, "R1", "idle during reset", {busy, done}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && z == '0, "R1", "idle after reset", z, 0);

    run_one(16'd1234, 16'd0, 16'd40001, 1'b0, "R4 zero exponent");
    run_one(16'd40000, 16'hFFFF, 16'd40001, 1'b0, "R4 all-ones exponent");
    run_one(16'd0, 16'd777, 16'd65535, 1'b0, "R4 zero base");
    run_one(16'd1, 16'hABCD, 16'd3, 1'b0, "R2 unit base");
    run_one(16'd65533, 16'h8001, 16'd65535, 1'b0, "R2 largest modulus");
    run_one(16'd2, 16'd5, 16'd3, 1'b0, "R2 smallest modulus");
    run_one(16'd3, 16'd7, 16'd1, 1'b0, "R2 modulus one");
    run_one(16'd321, 16'h1357, 16'd50021, 1'b1, "R5 R6 start while busy");

    for (int t = 0; t < 100; t++) begin
      n = W'($urandom) | 16'd1;
      if (n < 16'd3) n = 16'd3;
      y = W'($urandom % n);
      x = W'($urandom);
      run_one(y, x, n, 1'b0, "R2 random");
    end

    // R9: new start in the same cycle done is high
    e1 = model(16'd999, 16'h00F3, 16'd60007);
    e2 = model(16'd4321, 16'h0A0A, 16'd32769);
    @(negedge clk);
    drive(16'd999, 16'h00F3, 16'd60007);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    zfirst = z;
    chk(zfirst == W'(e1), "R9", "first result", zfirst, e1);
    drive(16'd4321, 16'h0A0A, 16'd32769);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9", "start in done cycle accepted", busy, 1);
    chk(z == zfirst, "R7", "z held after done", z, zfirst);
    while (!done) @(negedge clk);
    chk(z == W'(e2), "R9", "second result", z, e2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule